// File: doc/BRIEF.md
# Periodic Serial ADC Sampling Controller

This block is the master side of a three-wire link to a single-channel 12-bit serial converter. It produces a continuous serial clock from the system clock and an active-low chip select that also serves as the frame sync. It shifts in one 16-bit word per conversion frame from the converter's data line. An interval timer launches frames at a fixed spacing, measured in whole serial-clock periods. Each start is aligned to a serial-clock period boundary, so consecutive samples are evenly spaced and carry no phase jitter.

The 12-bit result is taken from the low end of the received word and is presented together with a one-cycle valid strobe. A power-down request is held until the next frame starts. That frame is then cut to an 8-clock burst, which sends the converter to sleep, and the following full frame wakes it. The divider setting and the interval setting are adopted only at a frame boundary. An enable input stops new frames from being launched.

Sequencer states are `SEQ_IDLE`, `SEQ_CONVERT` and `SEQ_SHUTDOWN`. The transitions are:
- `SEQ_IDLE` to `SEQ_CONVERT` on a timer start when no power-down is pending.
- `SEQ_IDLE` to `SEQ_SHUTDOWN` on a timer start when a power-down is pending.
- `SEQ_CONVERT` to `SEQ_IDLE` on the 16th serial rising edge.
- `SEQ_SHUTDOWN` to `SEQ_IDLE` on the 8th serial rising edge.

Top module: `adc_frame_sampler`

## Requirements
- R1: With divider setting d, the serial clock has a period of 2×(d+1) system cycles. It is high for the first d+1 cycles of each period and runs continuously.
- R2: Chip select falls only in the system cycle in which the serial clock rises, that is, on a period boundary.
- R3: While enabled, consecutive chip-select falling edges are exactly N_eff × 2×(d+1) system cycles apart, where N_eff is the interval setting in serial-clock periods.
- R4: An interval setting below 17 is treated as 17, so chip select stays high for at least one full serial period between frames.
- R5: A normal frame holds chip select low across exactly 16 serial rising edges, and chip select returns high at the 16th.
- R6: Data is sampled on serial rising edges, MSB first. The result is bits 11..0 of the received 16-bit word, and the top 4 bits are discarded.
- R7: `sample_valid` is a one-cycle pulse, high in the cycle in which chip select returns high after a normal frame. At all other times it is low, and `sample` holds its last value.
- R8: A `pd_req` pulse is latched and applies to the next frame that starts. That frame holds chip select low across exactly 8 serial rising edges, raises no valid strobe and leaves `sample` unchanged. The frame after it is a normal 16-edge frame.
- R9: Changes to `div_cfg` or `interval_cfg` made during a frame do not affect that frame's clock period or the spacing to the next start. They take effect from the next frame start onward.
- R10: While `enable` is low, no frame starts and chip select stays high. A frame already in progress completes.
- R11: During reset, `cs_n` and `sclk` are 1, `sample_valid` is 0 and `sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows frame launches when high |
| div_cfg | input | DIV_W | Serial divider setting d |
| interval_cfg | input | IVL_W | Frame spacing N in serial periods |
| pd_req | input | 1 | Request a power-down burst on the next frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select / frame sync |
| sclk | output | 1 | Serial clock |
| sample | output | RES_BITS | Right-justified conversion result |
| sample_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench builds the block with its default widths, DIV_W = 8 and IVL_W = 12. At run time it drives divider settings 3, 1 and 0, giving serial periods of 8, 4 and 2 cycles, including the fastest possible serial clock. It uses interval settings of 20, 24 and 5, where 5 exercises the clamp to 17. With these values every frame, the mid-frame configuration changes, the power-down burst and the enable gap all complete within a few thousand cycles. A converter model drives words whose top nibble is non-zero, so any failure to discard those bits appears in the result.

// File: rtl/adc_smp_pkg.sv
package adc_smp_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_CONVERT  = 2'd1,
        SEQ_SHUTDOWN = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             rise_o
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_last;
    logic [PH_W-1:0] ph_half;

    assign ph_last = {div_i, 1'b1};
    assign ph_half = {1'b0, div_i};
    assign rise_o  = (ph_q == ph_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            sclk_o <= 1'b1;
        end else if (ph_q == ph_last) begin
            ph_q   <= '0;
            sclk_o <= 1'b1;
        end else begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == ph_half) begin
                sclk_o <= 1'b0;
            end
        end
    end

    // R1: the phase counter never passes the end of the current period
    assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= ph_last);

endmodule

// File: rtl/adc_sample_timer.sv
module adc_sample_timer #(
    parameter int IVL_W   = 12,
    parameter int MIN_IVL = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [IVL_W-1:0] ivl_i,
    output logic             start_o
);
    logic [IVL_W-1:0] cnt_q;
    logic [IVL_W-1:0] ivl_eff;

    assign ivl_eff = (ivl_i < IVL_W'(MIN_IVL)) ? IVL_W'(MIN_IVL) : ivl_i;
    assign start_o = tick_i && run_i && (cnt_q == ivl_eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (!run_i || start_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: the count stays inside the clamped interval
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ivl_eff);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_smp_pkg::*;
#(
    parameter int WORD_BITS = 16,
    parameter int RES_BITS  = 12,
    parameter int PD_BITS   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                tick_i,
    input  logic                sdata_i,
    input  logic                pd_req_i,
    output logic                cs_n_o,
    output logic [RES_BITS-1:0] sample_o,
    output logic                valid_o
);
    localparam int CNT_W = $clog2(WORD_BITS);

    seq_state_t         state_q;
    seq_state_t         state_d;
    logic [CNT_W-1:0]   bits_q;
    logic [RES_BITS-2:0] shift_q;
    logic               pd_pend_q;
    logic               conv_done;
    logic               pd_done;

    assign conv_done = tick_i && (bits_q == CNT_W'(WORD_BITS - 1));
    assign pd_done   = tick_i && (bits_q == CNT_W'(PD_BITS - 1));
    assign cs_n_o    = (state_q == SEQ_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    state_d = pd_pend_q ? SEQ_SHUTDOWN : SEQ_CONVERT;
                end
            end
            SEQ_CONVERT: begin
                if (conv_done) begin
                    state_d = SEQ_IDLE;
                end
            end
            SEQ_SHUTDOWN: begin
                if (pd_done) begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q    <= '0;
            shift_q   <= '0;
            pd_pend_q <= 1'b0;
            sample_o  <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                bits_q <= '0;
                if (start_i) begin
                    pd_pend_q <= pd_req_i;
                end else if (pd_req_i) begin
                    pd_pend_q <= 1'b1;
                end
            end else begin
                if (pd_req_i) begin
                    pd_pend_q <= 1'b1;
                end
                if (tick_i) begin
                    bits_q <= bits_q + 1'b1;
                    if (state_q == SEQ_CONVERT) begin
                        shift_q <= {shift_q[RES_BITS-3:0], sdata_i};
                        if (conv_done) begin
                            sample_o <= {shift_q, sdata_i};
                            valid_o  <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R7: the strobe never lasts two cycles
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: a shortened burst never raises the strobe
    assert_shutdown_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SHUTDOWN) |=> !valid_o);

    // R8: a burst never runs past its edge count
    assert_burst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SHUTDOWN) |-> (bits_q < CNT_W'(PD_BITS)));

endmodule

// File: rtl/adc_frame_sampler.sv
module adc_frame_sampler #(
    parameter int DIV_W     = 8,
    parameter int IVL_W     = 12,
    parameter int WORD_BITS = 16,
    parameter int RES_BITS  = 12,
    parameter int PD_BITS   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [DIV_W-1:0]    div_cfg,
    input  logic [IVL_W-1:0]    interval_cfg,
    input  logic                pd_req,
    input  logic                sdata,
    output logic                cs_n,
    output logic                sclk,
    output logic [RES_BITS-1:0] sample,
    output logic                sample_valid
);
    localparam int MIN_IVL = WORD_BITS + 1;

    logic [DIV_W-1:0] div_act;
    logic [IVL_W-1:0] ivl_act;
    logic             period_edge;
    logic             frame_start;
    logic             cfg_load;

    assign cfg_load = period_edge && (frame_start || (cs_n && !enable));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_act <= '0;
            ivl_act <= '0;
        end else if (cfg_load) begin
            div_act <= div_cfg;
            ivl_act <= interval_cfg;
        end
    end

    adc_sclk_gen #(
        .DIV_W (DIV_W)
    ) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_act),
        .sclk_o (sclk),
        .rise_o (period_edge)
    );

    adc_sample_timer #(
        .IVL_W   (IVL_W),
        .MIN_IVL (MIN_IVL)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (period_edge),
        .run_i   (enable),
        .ivl_i   (ivl_act),
        .start_o (frame_start)
    );

    adc_frame_seq #(
        .WORD_BITS (WORD_BITS),
        .RES_BITS  (RES_BITS),
        .PD_BITS   (PD_BITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (frame_start),
        .tick_i   (period_edge),
        .sdata_i  (sdata),
        .pd_req_i (pd_req),
        .cs_n_o   (cs_n),
        .sample_o (sample),
        .valid_o  (sample_valid)
    );

    // R2: a frame opens only together with a serial rising edge
    assert_start_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $rose(sclk));

    // R10: no frame opens unless enabled
    assert_start_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(enable));

    // R7: the strobe coincides with the end of a frame
    assert_valid_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $rose(cs_n));

    // R9: settings move only at a frame start or while idle
    assert_cfg_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> (cs_n || $fell(cs_n)));

endmodule

// File: tb/adc_frame_sampler_tb.sv
module adc_frame_sampler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 100000;

    typedef struct packed {
        logic        pd;
        logic [15:0] word;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  div_cfg = 8'd3;
    logic [11:0] interval_cfg = 12'd20;
    logic        pd_req = 1'b0;
    logic        sdata = 1'b0;
    logic        cs_n;
    logic        sclk;
    logic [11:0] sample;
    logic        sample_valid;

    int checks = 0;
    int fails = 0;

    exp_t        exp_q[$];
    logic [15:0] tx_q[$];

    int  cyc = 0;
    int  per_cur = 8, per_next = 8;
    int  sp_cur = 160, sp_next = 160;
    bit  chk_per = 1'b0;
    bit  sp_armed = 1'b0;
    bit  pd_prev_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_sampler u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .div_cfg      (div_cfg),
        .interval_cfg (interval_cfg),
        .pd_req       (pd_req),
        .sdata        (sdata),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // converter model: bit 15-k is driven at the k-th serial falling edge of a frame
    initial begin
        logic [15:0] w;
        w = '0;
        forever begin
            @(negedge cs_n);
            for (int k = 0; k < 64; k++) begin
                @(negedge sclk or posedge cs_n);
                if (cs_n) break;
                if (k == 0) w = (tx_q.size() > 0) ? tx_q.pop_front() : 16'h0000;
                if (k < 16) sdata = w[15-k];
            end
        end
    end

    // monitor / scoreboard
    initial begin
        logic p_cs, p_sclk;
        int   last_rise, last_fall, rise_cnt;
        bit   have_rise;
        logic [11:0] held;
        exp_t e;
        p_cs = 1'b1; p_sclk = 1'b1; last_rise = 0; last_fall = 0;
        rise_cnt = 0; have_rise = 1'b0; held = '0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (rst_n) begin
                if (!p_sclk && sclk) begin
                    if (chk_per && have_rise)
                        chk((cyc - last_rise) == per_cur, "R1 sclk period", cyc - last_rise, per_cur);
                    last_rise = cyc;
                    have_rise = 1'b1;
                    if (!p_cs) rise_cnt++;
                end
                if (p_cs && !cs_n) begin
                    chk(!p_sclk && sclk, "R2 start aligned to sclk rise", int'(sclk), 1);
                    if (sp_armed)
                        chk((cyc - last_fall) == sp_cur, "R3/R4/R9 start spacing", cyc - last_fall, sp_cur);
                    last_fall = cyc;
                    sp_armed = 1'b1;
                    sp_cur = sp_next;
                    per_cur = per_next;
                    rise_cnt = 0;
                end
                if (!p_cs && cs_n) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected frame", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        if (e.pd) begin
                            chk(rise_cnt == 8, "R8 burst edge count", rise_cnt, 8);
                            chk(!sample_valid, "R8 no strobe on burst", int'(sample_valid), 0);
                            chk(sample == held, "R8 sample unchanged", int'(sample), int'(held));
                        end else begin
                            chk(rise_cnt == 16, "R5 frame edge count", rise_cnt, 16);
                            chk(sample_valid, "R7 strobe at frame end", int'(sample_valid), 1);
                            chk(sample == e.word[11:0], "R6 right-justified result", int'(sample), int'(e.word[11:0]));
                            held = e.word[11:0];
                        end
                    end
                end else if (sample_valid) begin
                    chk(1'b0, "R7 strobe outside frame end", 1, 0);
                end
            end
            p_cs = cs_n;
            p_sclk = sclk;
        end
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, WDOG_CYCLES);
        finish_run();
    end

    // driver: waits for a frame start and pushes what that frame must yield
    task automatic run_frame(input logic [15:0] w, input bit pd_next);
        exp_t e;
        @(negedge cs_n);
        #2;
        e.pd = pd_prev_req;
        e.word = w;
        exp_q.push_back(e);
        tx_q.push_back(w);
        pd_prev_req = pd_next;
        if (pd_next) begin
            @(negedge clk) pd_req = 1'b1;
            @(negedge clk) pd_req = 1'b0;
        end
    endtask

    task automatic set_cfg(input int d, input int n);
        int ne;
        @(negedge clk);
        div_cfg = 8'(d);
        interval_cfg = 12'(n);
        ne = (n < 17) ? 17 : n;
        per_next = 2 * (d + 1);
        sp_next = ne * per_next;
    endtask

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cs_n == 1'b1, "R11 cs_n in reset", int'(cs_n), 1);
        chk(sclk == 1'b1, "R11 sclk in reset", int'(sclk), 1);
        chk(sample_valid == 1'b0, "R11 valid in reset", int'(sample_valid), 0);
        chk(sample == 12'd0, "R11 sample in reset", int'(sample), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk_per = 1'b1;
        enable = 1'b1;

        // R6 various words, including a non-zero top nibble; d=3, N=20
        run_frame(16'h0ABC, 1'b0);
        run_frame(16'hF123, 1'b0);
        run_frame(16'h0000, 1'b0);
        run_frame(16'hA5A5, 1'b0);
        // R9 change mid-frame: d=1, N=24
        set_cfg(1, 24);
        run_frame(16'h0FFF, 1'b0);
        run_frame(16'h5800, 1'b0);
        run_frame(16'h3001, 1'b0);
        // R4 clamp with d=0 (fastest clock), N=5 -> 17
        set_cfg(0, 5);
        run_frame(16'hC7E2, 1'b0);
        run_frame(16'h0123, 1'b0);
        // R8 power-down burst then recovery
        run_frame(16'h0456, 1'b1);
        run_frame(16'hBEEF, 1'b0);
        run_frame(16'h0789, 1'b0);
        // R10 disable: frame in progress completes, then nothing starts
        @(negedge clk) enable = 1'b0;
        sp_armed = 1'b0;
        wait (exp_q.size() == 0);
        bad = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (!cs_n) bad++;
        end
        chk(bad == 0, "R10 cs_n held high while disabled", bad, 0);
        sp_armed = 1'b0;
        enable = 1'b1;
        run_frame(16'h0AAA, 1'b0);
        run_frame(16'h0555, 1'b0);
        @(negedge clk) enable = 1'b0;
        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule